// File: doc/BRIEF.md
# Single-Float Register Image Converter

This block moves single-precision values between their 32-bit memory form and the 64-bit form they take inside a floating-point register file. The register form keeps a double-width (11-bit) exponent field, so loading a single widens the exponent and storing narrows it again. The same block also packs a 32-bit longword integer into the register bit positions that a later store writes out. It reports when the 64-bit integer to be packed does not fit in 32 signed bits.

One of three paths is chosen on each cycle by a select input. Load takes the 32-bit memory word. Store and pack take the 64-bit register word. The outputs that the chosen path does not drive are held at zero. The logic is combinational. A parameter selects whether the outputs pass through one register stage, which is the default, or come straight from the logic. No arithmetic is done on the values.

Top module: `sfloat_reg_conv`

## Requirements
- R1: Load places memory bit 31 (sign) at register bit 63 and memory bits 22:0 (fraction) at register bits 51:29. Register bits 28:0 are zero.
- R2: Load with memory bit 30 set and memory bits 29:23 not all ones gives register exponent bits 62:52 = {1, 000, mem[29:23]}.
- R3: Load with memory bit 30 set and memory bits 29:23 all ones gives register exponent 0x7FF.
- R4: Load with memory bit 30 clear and memory bits 29:23 nonzero gives register exponent {0, 111, mem[29:23]}.
- R5: Load with memory bits 30:23 all zero gives register exponent zero.
- R6: Store gives mem_out[31:30] = reg_in[63:62] and mem_out[29:0] = reg_in[58:29]. All other register input bits are ignored.
- R7: Pack gives reg_out[63:62] = reg_in[31:30] and reg_out[58:29] = reg_in[29:0]. All other reg_out bits are zero.
- R8: During pack, int_ovf and inexact are both 1 when reg_in differs from the sign extension of reg_in[31:0]. Otherwise both are 0.
- R9: The select encoding is 0 = load, 1 = store, 2 = pack, 3 = none. Outputs that the selected path does not drive are zero. Both flags are zero outside pack. Code 3 drives every output to zero.
- R10: With OUT_REG=1, results appear one clock after their inputs. A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| path_sel | input | 2 | Path select: 0 load, 1 store, 2 pack, 3 none |
| mem_in | input | 32 | Memory image of a single (load source) |
| reg_in | input | 64 | Register image (store source) or 64-bit integer (pack source) |
| reg_out | output | 64 | Register image from load or pack |
| mem_out | output | 32 | Memory image from store |
| int_ovf | output | 1 | Pack input does not fit in 32 signed bits |
| inexact | output | 1 | Raised together with int_ovf |

## Verification
The bench drives each class of exponent: zero, denormal, the largest exponent with bit 30 clear (1.0), the smallest with bit 30 set (2.0), infinity and NaN. A converter that rebiased the exponent arithmetically, or that skipped the all-ones or all-zero special cases, would produce wrong exponents for infinity, NaN or zero. For pack, the bench sends values just inside and just outside the signed 32-bit range, including 0x80000000 both unsigned and sign-extended. A wrong overflow test would flag the wrong one of these, or raise only one of the two flags. On store, the bench fills the dropped register bits 61:59 and 28:0 with random data, so that any leak of those bits into mem_out shows up. Select code 3 and the outputs of unselected paths are checked to be zero.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int MEM_W     = 32;
  localparam int REG_W     = 64;
  localparam int MFRAC_W   = 23;
  localparam int MEXP_LO_W = 7;
  localparam int REXP_W    = 11;
  localparam int BODY_W    = 30;
  localparam int BODY_LSB  = 29;
  localparam int RFRAC_LSB = 29;
  localparam int GAP_W     = REXP_W - MEXP_LO_W - 1;

  typedef enum logic [1:0] {
    SEL_LOAD  = 2'd0,
    SEL_STORE = 2'd1,
    SEL_PACK  = 2'd2,
    SEL_NONE  = 2'd3
  } path_e;
endpackage

// File: rtl/sfc_load.sv
module sfc_load
  import sfc_pkg::*;
(
  input  logic [MEM_W-1:0] mem_word,
  output logic [REG_W-1:0] reg_word
);
  logic                 sgn;
  logic                 e_top;
  logic [MEXP_LO_W-1:0] e_low;
  logic [MFRAC_W-1:0]   frac;
  logic [REXP_W-1:0]    wide_exp;

  assign sgn   = mem_word[MEM_W-1];
  assign e_top = mem_word[MEM_W-2];
  assign e_low = mem_word[MEM_W-3 -: MEXP_LO_W];
  assign frac  = mem_word[MFRAC_W-1:0];

  // Exponent widening by remap on the top bit, not by rebias
  always_comb begin
    wide_exp = {e_top, {GAP_W{1'b0}}, e_low};
    if (e_top) begin
      if (&e_low) wide_exp = '1;
    end else if (|e_low) begin
      wide_exp[REXP_W-2 -: GAP_W] = '1;
    end
  end

  assign reg_word = {sgn, wide_exp, frac, {RFRAC_LSB{1'b0}}};
endmodule

// File: rtl/sfc_store.sv
module sfc_store
  import sfc_pkg::*;
(
  input  logic [1:0]        top_bits,
  input  logic [BODY_W-1:0] body_bits,
  output logic [MEM_W-1:0]  mem_word
);
  assign mem_word = {top_bits, body_bits};
endmodule

// File: rtl/sfc_pack.sv
module sfc_pack
  import sfc_pkg::*;
(
  input  logic [REG_W-1:0] int_word,
  output logic [REG_W-1:0] reg_word,
  output logic             ovf
);
  logic [REG_W-1:0] sext;

  assign sext     = {{(REG_W-MEM_W){int_word[MEM_W-1]}}, int_word[MEM_W-1:0]};
  assign ovf      = (sext != int_word);
  assign reg_word = {int_word[MEM_W-1 -: 2], {GAP_W{1'b0}},
                     int_word[BODY_W-1:0], {BODY_LSB{1'b0}}};
endmodule

// File: rtl/sfloat_reg_conv.sv
module sfloat_reg_conv
  import sfc_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          path_sel,
  input  logic [MEM_W-1:0]    mem_in,
  input  logic [REG_W-1:0]    reg_in,
  output logic [REG_W-1:0]    reg_out,
  output logic [MEM_W-1:0]    mem_out,
  output logic                int_ovf,
  output logic                inexact
);
  path_e            sel;
  logic [REG_W-1:0] ld_word, pk_word, reg_nx;
  logic [MEM_W-1:0] st_word, mem_nx;
  logic             pk_ovf, flag_nx;

  assign sel = path_e'(path_sel);

  sfc_load u_load (.mem_word(mem_in), .reg_word(ld_word));

  sfc_store u_store (
    .top_bits (reg_in[REG_W-1 -: 2]),
    .body_bits(reg_in[BODY_LSB +: BODY_W]),
    .mem_word (st_word)
  );

  sfc_pack u_pack (.int_word(reg_in), .reg_word(pk_word), .ovf(pk_ovf));

  always_comb begin
    reg_nx  = '0;
    mem_nx  = '0;
    flag_nx = 1'b0;
    unique case (sel)
      SEL_LOAD:  reg_nx = ld_word;
      SEL_STORE: mem_nx = st_word;
      SEL_PACK: begin
        reg_nx  = pk_word;
        flag_nx = pk_ovf;
      end
      default: ;
    endcase
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          reg_out <= '0;
          mem_out <= '0;
          int_ovf <= 1'b0;
          inexact <= 1'b0;
        end else begin
          reg_out <= reg_nx;
          mem_out <= mem_nx;
          int_ovf <= flag_nx;
          inexact <= flag_nx;
        end
      end

      logic past_ok;
      always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
      end

      a_r1_load_low_zero: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(path_sel) == SEL_LOAD |->
          reg_out[RFRAC_LSB-1:0] == '0 && reg_out[REG_W-1] == $past(mem_in[MEM_W-1]));
      a_r4_load_gap_uniform: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(path_sel) == SEL_LOAD |->
          (reg_out[61:59] == 3'b000 || reg_out[61:59] == 3'b111));
      a_r6_store_map: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(path_sel) == SEL_STORE |->
          mem_out == {$past(reg_in[63:62]), $past(reg_in[58:29])});
      a_r7_pack_zero_gaps: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(path_sel) == SEL_PACK |->
          reg_out[61:59] == 3'b000 && reg_out[28:0] == '0);
      a_r8_flags_paired: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> int_ovf == inexact);
      a_r9_flags_pack_only: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(path_sel) != SEL_PACK |-> !int_ovf);
      a_r9_mem_store_only: assert property (@(posedge clk) disable iff (rst)
        past_ok && $past(path_sel) != SEL_STORE |-> mem_out == '0);
    end else begin : g_comb
      assign reg_out = reg_nx;
      assign mem_out = mem_nx;
      assign int_ovf = flag_nx;
      assign inexact = flag_nx;
    end
  endgenerate
endmodule

// File: tb/sfloat_reg_conv_tb.sv
`timescale 1ns/1ps
module sfloat_reg_conv_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  path_sel;
  logic [31:0] mem_in;
  logic [63:0] reg_in;
  logic [63:0] reg_out;
  logic [31:0] mem_out;
  logic        int_ovf, inexact;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sfloat_reg_conv u_dut (
    .clk(clk), .rst(rst), .path_sel(path_sel), .mem_in(mem_in), .reg_in(reg_in),
    .reg_out(reg_out), .mem_out(mem_out), .int_ovf(int_ovf), .inexact(inexact)
  );

  function automatic logic [63:0] exp_load(input logic [31:0] m);
    logic [10:0] e;
    if (m[30] == 1'b1 && m[29:23] == 7'h7F)      e = 11'h7FF;
    else if (m[30] == 1'b1)                      e = 11'h400 + {4'b0, m[29:23]};
    else if (m[29:23] != 7'h00)                  e = 11'h380 + {4'b0, m[29:23]};
    else                                         e = 11'h000;
    exp_load = 64'(m[31]) << 63 | 64'(e) << 52 | 64'(m[22:0]) << 29;
  endfunction

  function automatic logic [31:0] exp_store(input logic [63:0] r);
    exp_store = (32'(r[63:62]) << 30) | 32'(r[58:29]);
  endfunction

  function automatic logic [63:0] exp_pack(input logic [63:0] v);
    exp_pack = (64'(v[31:30]) << 62) | (64'(v[29:0]) << 29);
  endfunction

  function automatic logic exp_ovf(input logic [63:0] v);
    longint s;
    s = longint'(signed'(v[31:0]));
    exp_ovf = (s != longint'(v));
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] s, input logic [31:0] m, input logic [63:0] r);
    @(negedge clk);
    path_sel = s; mem_in = m; reg_in = r;
    @(posedge clk); #1;
  endtask

  task automatic do_load(input logic [31:0] m, input string req);
    apply(2'd0, m, $urandom());
    chk(req, reg_out, exp_load(m));
    chk("R9 load mem_out zero", {32'b0, mem_out}, 64'd0);
    chk("R9 load flags zero", {62'b0, int_ovf, inexact}, 64'd0);
  endtask

  task automatic do_store(input logic [63:0] r);
    apply(2'd1, $urandom(), r);
    chk("R6 store", {32'b0, mem_out}, {32'b0, exp_store(r)});
    chk("R9 store reg_out zero", reg_out, 64'd0);
  endtask

  task automatic do_pack(input logic [63:0] v);
    logic f;
    apply(2'd2, $urandom(), v);
    f = exp_ovf(v);
    chk("R7 pack", reg_out, exp_pack(v));
    chk("R8 pack flags", {62'b0, int_ovf, inexact}, {62'b0, f, f});
    chk("R9 pack mem_out zero", {32'b0, mem_out}, 64'd0);
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst = 1'b1; path_sel = 2'd0; mem_in = 32'h3F800000; reg_in = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset reg_out", reg_out, 64'd0);
    chk("R10 reset mem_out", {32'b0, mem_out}, 64'd0);
    chk("R10 reset flags", {62'b0, int_ovf, inexact}, 64'd0);
    @(negedge clk); rst = 1'b0;

    do_load(32'h00000000, "R5 zero");
    do_load(32'h80000000, "R5 negative zero");
    do_load(32'h00000001, "R5 denormal");
    do_load(32'h3F800000, "R4 one");
    do_load(32'h00800000, "R4 smallest normal");
    do_load(32'h40000000, "R2 two");
    do_load(32'h7F000000, "R2 large");
    do_load(32'h7F800000, "R3 infinity");
    do_load(32'hFFC00001, "R3 NaN");
    do_load(32'hC0FFFFFF, "R1 sign and fraction");

    do_store(64'h3FF0000000000000);
    do_store(64'h4380000000000000);
    do_store(64'hFFFFFFFFFFFFFFFF);
    do_store(64'h3800000000000000);

    do_pack(64'h000000007FFFFFFF);
    do_pack(64'h0000000080000000);
    do_pack(64'hFFFFFFFF80000000);
    do_pack(64'hFFFFFFFF7FFFFFFF);
    do_pack(64'h0000000100000000);
    do_pack(64'h0);

    apply(2'd3, 32'hFFFFFFFF, 64'hFFFFFFFFFFFFFFFF);
    chk("R9 none reg_out", reg_out, 64'd0);
    chk("R9 none mem_out", {32'b0, mem_out}, 64'd0);
    chk("R9 none flags", {62'b0, int_ovf, inexact}, 64'd0);

    // R10 latency: the output must still hold the previous result before the edge
    @(negedge clk);
    path_sel = 2'd0; mem_in = 32'h40000000;
    #1;
    chk("R10 one-cycle latency", reg_out, 64'd0);
    @(posedge clk); #1;
    chk("R10 registered load", reg_out, 64'h4000000000000000);

    for (int i = 0; i < 400; i++) begin
      logic [63:0] r;
      int k;
      k = $urandom_range(0, 2);
      r = {$urandom(), $urandom()};
      if (k == 0) do_load($urandom(), "R1 random load");
      else if (k == 1) do_store(r);
      else begin
        if ($urandom_range(0, 1) == 1) r = {{32{r[31]}}, r[31:0]};
        do_pack(r);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule